// File: doc/BRIEF.md
# Reference-Ratio Clock Frequency Meter

This block finds the frequency of an unknown clock by counting cycles of a free-running reference clock. The count covers a window made of a programmed number of cycles of the unknown clock. Up to four candidate clocks come in on a small input vector. Each one is resynchronized into the reference domain and reduced to a one-cycle rising-edge pulse.

Software uses three registers. It writes a window length and a source index, then sets a free-run enable and a detect enable. It then polls a valid flag and reads the count. The source frequency follows as `target * f_ref / count`. A typical window is 1024 source cycles.

The window opens at the first source edge seen after arming, so a source with an integer period of P reference cycles reads back exactly `target * P`. A count that would overflow the reference counter stops at its all-ones value and is still reported as complete.

Top module: `freq_meter`

## Requirements
- R1: After reset, all three registers read zero. The valid flag is 0 and the result is 0.
- R2: The control register is at byte address 0x00. Bits 23:0 hold the window length in source cycles, bit 24 is the detect enable and bits 27:26 are the source index. It reads back as written, and bits 25 and 31:28 read 0.
- R3: The monitor register is at 0x10. Bit 8 is the free-run enable and reads back as written. Bit 0 is the valid flag, which is read-only: writing it has no effect. All other bits read 0.
- R4: The result register is at 0x0C and is read-only. It holds the number of reference cycles from the first detected source rising edge after arming to the target-th rising edge after it. For a source of period P reference cycles it reads `target * P`, and valid is then 1.
- R5: The source index selects input `mon_clk[index]`. Other inputs do not affect the measurement.
- R6: Counting advances only while both the detect enable and the free-run enable are 1. If the free-run enable is 0, valid stays 0 and the count freezes until it is set.
- R7: Writing the detect enable to 0 clears valid and the internal counters within one cycle. The result register keeps its last value. Setting the enable again starts a new measurement.
- R8: If the count reaches `2**REF_W - 1` before the window closes, the measurement stops with that value as the result and valid set to 1.
- R9: A window length of 0 completes at the first detected source edge, with result 0 and valid set to 1.
- R10: The result register changes only in the cycle in which a measurement completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mon_clk | input | N_SRC | Candidate source clocks, asynchronous to `clk` |

## Verification
A corrupted edge counter or window state shows up as a result that is not the exact `target * P` product. The result is visible at the result register on the same poll that first sees valid, at most a few thousand cycles after arming. A broken synchronizer or source select shows up the same way, because the other inputs run at deliberately different periods. A wrong enable or clear path shows up at the monitor register. Valid then rises while the free-run enable is 0, or stays 1 one cycle after the detect enable is cleared. A result that changes without completion shows up when the result register is read during a frozen measurement.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int DATA_W   = 32;
    localparam int TARGET_W = 24;
    localparam int SEL_W    = 2;

    // Register byte addresses (fixed map)
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_RESULT = 8'h0C;
    localparam logic [7:0] OFS_MON    = 8'h10;

    // Field positions
    localparam int CTRL_DET_BIT = 24;
    localparam int CTRL_SEL_LO  = 26;
    localparam int MON_FRK_BIT  = 8;
    localparam int MON_VLD_BIT  = 0;

    typedef struct packed {
        logic [SEL_W-1:0]    src;
        logic                det_en;
        logic [TARGET_W-1:0] target;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } meas_state_e;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[TARGET_W-1:0] = c.target;
        w[CTRL_DET_BIT] = c.det_en;
        w[CTRL_SEL_LO +: SEL_W] = c.src;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.target = w[TARGET_W-1:0];
        c.det_en = w[CTRL_DET_BIT];
        c.src    = w[CTRL_SEL_LO +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] async_in,
    output logic [N_CH-1:0] rise
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_in[ch];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign rise[ch] = sync_q & ~prev_q;
    end
endmodule

// File: rtl/fm_regs.sv
module fm_regs
    import fm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int REF_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              meas_valid,
    input  logic [REF_W-1:0]  meas_result,
    output ctrl_t             ctrl_q,
    output logic              frk_en_q
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFS_RESULT);
    localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(OFS_MON);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            frk_en_q <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) ctrl_q   <= word_to_ctrl(bus_wdata);
            if (bus_addr == A_MON)  frk_en_q <= bus_wdata[MON_FRK_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
            A_RES:  bus_rdata = DATA_W'(meas_result);
            A_MON: begin
                bus_rdata[MON_FRK_BIT] = frk_en_q;
                bus_rdata[MON_VLD_BIT] = meas_valid;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fm_core.sv
module fm_core
    import fm_pkg::*;
#(
    parameter int REF_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                det_en,
    input  logic                frk_en,
    input  logic [TARGET_W-1:0] target,
    input  logic                src_rise,
    output logic                valid,
    output logic [REF_W-1:0]    result,
    output meas_state_e         state,
    output logic [REF_W-1:0]    ref_cnt
);
    localparam logic [REF_W-1:0] REF_MAX = '1;

    logic [TARGET_W-1:0] edge_cnt;
    logic [REF_W-1:0]    ref_nxt;
    logic [TARGET_W-1:0] edge_nxt;
    logic                win_end;

    assign ref_nxt  = ref_cnt + 1'b1;
    assign edge_nxt = edge_cnt + 1'b1;
    assign win_end  = (src_rise && edge_nxt == target) || (ref_nxt == REF_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ref_cnt  <= '0;
            edge_cnt <= '0;
            valid    <= 1'b0;
            result   <= '0;
        end else if (!det_en) begin
            state    <= ST_IDLE;
            ref_cnt  <= '0;
            edge_cnt <= '0;
            valid    <= 1'b0;
        end else if (frk_en) begin
            case (state)
                ST_IDLE: state <= ST_ARMED;
                ST_ARMED: begin
                    if (src_rise) begin
                        ref_cnt  <= '0;
                        edge_cnt <= '0;
                        if (target == '0) begin
                            result <= '0;
                            valid  <= 1'b1;
                            state  <= ST_DONE;
                        end else begin
                            state <= ST_COUNT;
                        end
                    end
                end
                ST_COUNT: begin
                    ref_cnt <= ref_nxt;
                    if (src_rise) edge_cnt <= edge_nxt;
                    if (win_end) begin
                        result <= ref_nxt;
                        valid  <= 1'b1;
                        state  <= ST_DONE;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int N_SRC  = 4,
    parameter int REF_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_SRC-1:0]  mon_clk
);
    ctrl_t              ctrl_q;
    logic               frk_en_q;
    logic               meas_valid;
    logic [REF_W-1:0]   meas_result;
    logic [N_SRC-1:0]   src_rises;
    logic               sel_rise;
    meas_state_e        meas_state;
    logic [REF_W-1:0]   ref_cnt;

    fm_regs #(.ADDR_W(ADDR_W), .REF_W(REF_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .meas_valid(meas_valid), .meas_result(meas_result),
        .ctrl_q(ctrl_q), .frk_en_q(frk_en_q)
    );

    fm_sync_edge #(.N_CH(N_SRC)) u_sync (
        .clk(clk), .rst(rst), .async_in(mon_clk), .rise(src_rises)
    );

    always_comb begin
        sel_rise = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (ctrl_q.src == SEL_W'(i)) sel_rise = src_rises[i];
    end

    fm_core #(.REF_W(REF_W)) u_core (
        .clk(clk), .rst(rst),
        .det_en(ctrl_q.det_en), .frk_en(frk_en_q),
        .target(ctrl_q.target), .src_rise(sel_rise),
        .valid(meas_valid), .result(meas_result),
        .state(meas_state), .ref_cnt(ref_cnt)
    );
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk
    import fm_pkg::*;
#(
    parameter int REF_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             det_en,
    input logic             frk_en,
    input logic             valid,
    input logic [REF_W-1:0] result,
    input meas_state_e      st,
    input logic [REF_W-1:0] ref_cnt
);
    localparam logic [REF_W-1:0] REF_MAX = '1;

    a_r7_clear_valid: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> !valid);

    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (det_en && !frk_en) |=> ($stable(ref_cnt) && $stable(valid)));

    a_r6_needs_enables: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(det_en && frk_en));

    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COUNT && det_en && frk_en && ref_cnt == REF_MAX - 1'b1)
        |=> (valid && result == REF_MAX));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(valid) |-> $stable(result));

    a_r4_valid_done: assert property (@(posedge clk) disable iff (rst)
        valid |-> st == ST_DONE);
endmodule

bind freq_meter freq_meter_chk #(.REF_W(REF_W)) u_chk (
    .clk(clk), .rst(rst),
    .det_en(ctrl_q.det_en), .frk_en(frk_en_q),
    .valid(meas_valid), .result(meas_result),
    .st(meas_state), .ref_cnt(ref_cnt)
);

// File: tb/freq_meter_test.sv
module freq_meter_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W      = 12;
    localparam int REF_MAX    = (1 << REF_W) - 1;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  mon_clk = '0;

    int per [4] = '{3, 4, 5, 6};
    int ph  [4] = '{0, 0, 0, 0};
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    freq_meter #(.ADDR_W(5), .N_SRC(4), .REF_W(REF_W)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mon_clk(mon_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (ph[i] >= per[i] - 1) ph[i] <= 0;
            else ph[i] <= ph[i] + 1;
            mon_clk[i] <= (ph[i] < per[i] / 2);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int expect_count(int tgt, int p);
        longint v;
        v = longint'(tgt) * longint'(p);
        if (v > REF_MAX) v = REF_MAX;
        return int'(v);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_valid(int limit, output bit ok);
        logic [31:0] m;
        ok = 1'b0;
        for (int k = 0; k < limit; k++) begin
            rd(5'h10, m);
            if (m[0]) begin ok = 1'b1; break; end
        end
    endtask

    function automatic logic [31:0] ctrl_word(int tgt, int src, bit det);
        return (32'(src) << 26) | (32'(det) << 24) | (32'(tgt) & 32'hFF_FFFF);
    endfunction

    // Arm a measurement on source src with period p and window tgt, then check the result.
    task automatic measure(string req, int src, int p, int tgt);
        logic [31:0] v;
        bit ok;
        wr(5'h00, 32'h0);
        for (int i = 0; i < 4; i++) per[i] = p + 1 + i;   // R5: others differ
        per[src] = p;
        repeat (40) @(negedge clk);
        wr(5'h10, 32'h100);
        wr(5'h00, ctrl_word(tgt, src, 1'b1));
        wait_valid(REF_MAX + 200, ok);
        check({req, " valid"}, 32'(ok), 32'd1);
        rd(5'h0C, v);
        check({req, " result"}, v, 32'(expect_count(tgt, p)));
    endtask

    initial begin
        logic [31:0] v, held;
        bit ok;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, v); check("R1 ctrl", v, 32'h0);
        rd(5'h0C, v); check("R1 result", v, 32'h0);
        rd(5'h10, v); check("R1 mon", v, 32'h0);

        // R2 control readback (free-run off, so nothing counts)
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v); check("R2 ctrl readback", v, 32'h0DFF_FFFF);
        wr(5'h00, 32'h0);

        // R3 valid bit is read-only
        wr(5'h10, 32'h0000_0101);
        rd(5'h10, v); check("R3 mon write", v, 32'h0000_0100);
        wr(5'h10, 32'h0);
        rd(5'h10, v); check("R3 mon clear", v, 32'h0);

        // R4 typical window and R5 each source
        measure("R4 tgt1024", 0, 3, 1024);
        measure("R5 src1", 1, 2, 100);
        measure("R5 src2", 2, 7, 50);
        measure("R5 src3", 3, 4, 333);

        // R9 zero window
        measure("R9 zero", 1, 5, 0);

        // R8 saturation
        measure("R8 sat", 0, 5, 1024);
        measure("R8 edge", 2, 4, 1024);

        // R6 no counting without free-run enable; R10 result held meanwhile
        rd(5'h0C, held);
        wr(5'h00, 32'h0);
        wr(5'h10, 32'h0);
        per[1] = 3;
        wr(5'h00, ctrl_word(10, 1, 1'b1));
        repeat (200) @(negedge clk);
        rd(5'h10, v); check("R6 no valid", v, 32'h0);
        rd(5'h0C, v); check("R10 result held", v, held);
        wr(5'h10, 32'h100);
        wait_valid(500, ok);
        check("R6 resumes valid", 32'(ok), 32'd1);
        rd(5'h0C, v); check("R6 resumes result", v, 32'd30);

        // R7 clearing detect clears valid, keeps result
        wr(5'h00, ctrl_word(10, 1, 1'b0));
        rd(5'h10, v); check("R7 valid cleared", v, 32'h100);
        rd(5'h0C, v); check("R7 result kept", v, 32'd30);
        wr(5'h00, ctrl_word(20, 1, 1'b1));
        wait_valid(500, ok);
        check("R7 restart valid", 32'(ok), 32'd1);
        rd(5'h0C, v); check("R7 restart result", v, 32'd60);

        // Random mix, R4 R5 R8
        for (int n = 0; n < 16; n++) begin
            int s, p, t;
            s = int'($urandom_range(3, 0));
            p = int'($urandom_range(20, 2));
            t = int'($urandom_range(300, 1));
            measure("R4 random", s, p, t);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule